// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block is a watchdog timer serviced through a single byte-wide arm register on a simple write port: a write strobe with 8-bit data. A 3-bit rate field turns the watchdog off when it is zero. Any nonzero value turns it on and selects a time-out period of `2^(BASE_SHIFT + rate)` clock cycles. To restart the period, software writes the arming key `0x55` and later the service key `0xAA`. Cycles with no write may fall between the two keys. If the period runs out, or any other byte is written, the block raises a one-cycle reset request.

An optional window mode limits when software may service the watchdog. In window mode, every write that lands in the first three quarters of the period is itself a violation. Servicing is legal only once the counter reaches `3*P/4`. Reading the register always returns zero.

The control is a three-state machine:

- **OFF**: the rate field is zero. The counter is held at zero and every write is ignored.
- **IDLE**: the block is enabled and waits for the arming key.
- **ARMED**: `0x55` has been seen.

The transitions are:

- **enable**: OFF goes to IDLE when the rate field becomes nonzero.
- **disable**: any state goes to OFF when the rate field returns to zero.
- **arm**: IDLE or ARMED goes to ARMED on a write of `0x55`.
- **service**: ARMED goes to IDLE on a write of `0xAA`. The counter restarts.
- **violate**: any enabled state goes to IDLE on one of these events:
  - a stray byte;
  - `0xAA` written while in IDLE;
  - an early write in window mode;
  - expiry.

  The violate transition also pulses the reset request and clears the counter.

Top module: `wdog_window_top`

## Requirements
- R1: While `rate_sel` is 000, the block is off: writes have no effect and `wdog_rst` stays low.
- R2: `rd_data` is always 0x00.
- R3: While enabled, a write of any byte other than 0x55 or 0xAA raises `wdog_rst` on the clock edge that samples the write.
- R4: While enabled, a write of 0xAA with no pending 0x55 is treated as a stray byte and raises `wdog_rst`.
- R5: A write of 0xAA that follows a write of 0x55 restarts the period, with or without idle cycles between them. The next expiry falls P cycles after the 0xAA edge.
- R6: Several 0x55 writes in a row are legal and keep the sequence armed for the 0xAA.
- R7: With no service, `wdog_rst` rises on the P-th clock edge after the last restart, where P = 2^(BASE_SHIFT + rate_sel). A 0xAA that completes on the terminal cycle counts as a service.
- R8: With `window_en` high, any write sampled while the count is below 3P/4 raises `wdog_rst`. Writes at counts of 3P/4 and above follow the normal key rules.
- R9: `wdog_rst` is one cycle wide. After it, the counter restarts from zero and any pending 0x55 is forgotten.
- R10: The rate field selects the period. For example, rate 2 gives twice the period of rate 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Rate field: 000 turns the watchdog off, otherwise it selects the period exponent |
| window_en | input | 1 | Window mode enable |
| wr_en | input | 1 | Write strobe for the arm register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data of the arm register, always zero |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
Every reset request is registered, so each result has a fixed due time:

- a stray byte, an unarmed 0xAA or an early window write shows on `wdog_rst` one edge after the write is sampled;
- an expiry shows on exactly the P-th edge after a restart.

The bench drives inputs and samples outputs on the falling edge. Each scenario starts from a known count by forcing a restart with a stray byte. It then counts edges, requires `wdog_rst` to stay low before the due edge and to be high on it, and checks that the pulse is gone one edge later. Window boundaries are hit on the counts 3P/4-1 and 3P/4.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_IDLE  = 2'd1,
        WD_ARMED = 2'd2
    } wd_state_t;

    localparam logic [7:0] KEY_ARM     = 8'h55;
    localparam logic [7:0] KEY_SERVICE = 8'hAA;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int BASE_SHIFT = 4,
    parameter int RATE_W     = 3,
    parameter int CNT_W      = BASE_SHIFT + (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  cnt,
    output logic              expire,
    output logic              in_window
);
    localparam int PW = CNT_W + 1;

    logic [PW-1:0] period;
    logic [PW-1:0] cnt_ext;

    always_comb begin
        period    = {{(PW-1){1'b0}}, 1'b1} << (BASE_SHIFT + int'(rate));
        cnt_ext   = {1'b0, cnt};
        expire    = enable && (cnt_ext >= period - 1'b1);
        in_window = cnt_ext >= (period - (period >> 2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!enable || clear)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       window_en,
    input  logic       in_window,
    input  logic       expire,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       clear,
    output logic       svc,
    output logic       rst_req
);
    wd_state_t state, state_nx;
    logic      fire;

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        svc      = 1'b0;
        if (!enable) begin
            state_nx = WD_OFF;
        end else begin
            unique case (state)
                WD_OFF:   state_nx = WD_IDLE;
                WD_IDLE:  state_nx = WD_IDLE;
                WD_ARMED: state_nx = WD_ARMED;
                default:  state_nx = WD_IDLE;
            endcase
            if (wr_en) begin
                if (window_en && !in_window)
                    fire = 1'b1;
                else if (wr_data == KEY_ARM)
                    state_nx = WD_ARMED;
                else if (wr_data == KEY_SERVICE && state == WD_ARMED) begin
                    svc      = 1'b1;
                    state_nx = WD_IDLE;
                end else
                    fire = 1'b1;
            end
            if (expire && !svc)
                fire = 1'b1;
            if (fire)
                state_nx = WD_IDLE;
        end
        clear = svc || fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= fire;
    end

    a_r1_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rst_req);

    a_r3_stray_byte_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en && wr_data != KEY_ARM && wr_data != KEY_SERVICE) |=> rst_req);

    a_r8_early_write_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && window_en && wr_en && !in_window) |=> rst_req);
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top #(
    parameter int BASE_SHIFT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    input  logic       window_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       wdog_rst
);
    localparam int RATE_W = 3;
    localparam int CNT_W  = BASE_SHIFT + (1 << RATE_W) - 1;

    logic             enable;
    logic             clear;
    logic             svc;
    logic             expire;
    logic             in_window;
    logic [CNT_W-1:0] cnt;

    assign enable  = (rate_sel != '0);
    assign rd_data = '0;

    wdog_timebase #(
        .BASE_SHIFT (BASE_SHIFT),
        .RATE_W     (RATE_W),
        .CNT_W      (CNT_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .clear     (clear),
        .rate      (rate_sel),
        .cnt       (cnt),
        .expire    (expire),
        .in_window (in_window)
    );

    wdog_key_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .window_en (window_en),
        .in_window (in_window),
        .expire    (expire),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .clear     (clear),
        .svc       (svc),
        .rst_req   (wdog_rst)
    );

    a_r5_service_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (cnt == '0) && !wdog_rst);

    a_r7_expiry_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !svc) |=> wdog_rst);

    a_r9_pulse_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (cnt == '0));
endmodule

// File: tb/wdog_window_top_tb.sv
`timescale 1ns/1ps
module wdog_window_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       window_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdog_rst;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    wdog_window_top #(.BASE_SHIFT(4)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .window_en (window_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wdog_rst  (wdog_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Drives one write at the current falling edge and returns at the falling edge after it is sampled.
    task automatic write_byte(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    // Forces a restart with a stray byte, so the count is zero afterwards.
    task automatic sync_clear(input string req);
        write_byte(8'h00);
        check(wdog_rst === 1'b1, req, int'(wdog_rst), 1);
    endtask

    task automatic expect_expiry(input int n, input string req);
        int early = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < n && wdog_rst) early++;
        end
        check(early == 0, req, early, 0);
        check(wdog_rst === 1'b1, req, int'(wdog_rst), 1);
    endtask

    task automatic t_reset;
        check(rd_data === 8'h00, "R2", int'(rd_data), 0);
        check(wdog_rst === 1'b0, "R9", int'(wdog_rst), 0);
    endtask

    task automatic t_disabled;
        int seen = 0;
        rate_sel = 3'd0;
        write_byte(8'h12);
        if (wdog_rst) seen++;
        write_byte(8'hAA);
        if (wdog_rst) seen++;
        for (int i = 0; i < 100; i++) begin
            tick(1);
            if (wdog_rst) seen++;
        end
        check(seen == 0, "R1", seen, 0);
        check(rd_data === 8'h00, "R2", int'(rd_data), 0);
    endtask

    task automatic t_expiry;
        rate_sel = 3'd1;
        expect_expiry(32, "R7");
        tick(1);
        check(wdog_rst === 1'b0, "R9", int'(wdog_rst), 0);
        expect_expiry(31, "R7");
    endtask

    task automatic t_stray;
        write_byte(8'h3C);
        check(wdog_rst === 1'b1, "R3", int'(wdog_rst), 1);
        tick(1);
        check(wdog_rst === 1'b0, "R9", int'(wdog_rst), 0);
    endtask

    task automatic t_unarmed_service;
        sync_clear("R3");
        tick(3);
        write_byte(8'hAA);
        check(wdog_rst === 1'b1, "R4", int'(wdog_rst), 1);
    endtask

    task automatic t_split_service;
        sync_clear("R3");
        tick(10);
        write_byte(8'h55);
        tick(6);
        write_byte(8'hAA);
        check(wdog_rst === 1'b0, "R5", int'(wdog_rst), 0);
        expect_expiry(32, "R5");
    endtask

    task automatic t_repeat_arm;
        sync_clear("R3");
        write_byte(8'h55);
        tick(2);
        write_byte(8'h55);
        write_byte(8'h55);
        check(wdog_rst === 1'b0, "R6", int'(wdog_rst), 0);
        tick(4);
        write_byte(8'hAA);
        check(wdog_rst === 1'b0, "R6", int'(wdog_rst), 0);
        expect_expiry(32, "R6");
    endtask

    task automatic t_flag_cleared;
        sync_clear("R3");
        write_byte(8'h55);
        write_byte(8'h07);
        check(wdog_rst === 1'b1, "R3", int'(wdog_rst), 1);
        write_byte(8'hAA);
        check(wdog_rst === 1'b1, "R9", int'(wdog_rst), 1);
    endtask

    task automatic t_rate;
        rate_sel = 3'd2;
        sync_clear("R3");
        expect_expiry(64, "R10");
        rate_sel = 3'd1;
    endtask

    task automatic t_window;
        window_en = 1'b1;
        sync_clear("R8");
        tick(5);
        write_byte(8'h55);
        check(wdog_rst === 1'b1, "R8", int'(wdog_rst), 1);
        tick(23);
        write_byte(8'h55);
        check(wdog_rst === 1'b1, "R8", int'(wdog_rst), 1);
        tick(24);
        write_byte(8'h55);
        check(wdog_rst === 1'b0, "R8", int'(wdog_rst), 0);
        write_byte(8'hAA);
        check(wdog_rst === 1'b0, "R8", int'(wdog_rst), 0);
        expect_expiry(32, "R8");
        window_en = 1'b0;
    endtask

    initial begin
        #(4ns * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_expiry();
        t_stray();
        t_unarmed_service();
        t_split_service();
        t_repeat_arm();
        t_flag_cleared();
        t_rate();
        t_window();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule